// File: doc/BRIEF.md
# Auto-Reload Timer with Prescaler

This block is an 8-bit up-counter for a small peripheral bus. The counter advances on count ticks. A count tick is produced by a clock-source selector followed by a power-of-two prescaler. The selector offers four choices: every system clock, every third system clock, rising edges of an external pin, or nothing. All of these are single-cycle enable pulses in the system clock domain, so the block never generates a clock.

When the counter passes 0xFF it takes its next value from a reload register on that same tick. A compare register drives a level output and a sticky match flag. The external pin is synchronised and can also serve as a restart source. When restart is enabled, a selected edge of the pin reloads the counter and zeroes the prescaler.

Software uses the bus to program the control, reload and compare registers. A live window onto the counter can be read, or written to place a new count immediately. Two sticky event flags are cleared by writing 1 to them. The bus is a plain register port. Every access completes in the cycle it is presented, so there is no valid/ready handshake and no back-pressure. Read data is combinational from the address.

Top module: `reload_timer`

## Requirements
- R1: Control bits [7:5] hold a code N from 0 to 7. With a source selected, the counter advances exactly once per 2^N source pulses. Over any window of k·2^N system cycles with the every-cycle source, it advances k times.
- R2: Control bit 4 always reads 0, whatever value is written to it.
- R3: Control bit 2 enables restart and bit 3 picks its polarity (0 for a rising edge, 1 for a falling edge). A qualifying edge of the pin, after a two-flop synchroniser, loads the counter from the reload register. An edge of the other polarity, or any edge while bit 2 is 0, leaves the counter unchanged.
- R4: Control bits [1:0] select the source. 00 is every system clock, 01 is every third system clock, 10 is each synchronised rising edge of the pin, and 11 stops counting.
- R5: A tick taken at 0xFF loads the counter from the reload register and sets the overflow flag.
- R6: Offset 4 reads the live counter. A write there sets the counter at the next clock edge. That write takes precedence over a tick, a reload or a restart in the same cycle, and no overflow is flagged for it.
- R7: After reset, control, status, reload and compare all read 0. The counter itself is not initialised by reset.
- R8: The compare-match flag is set when a tick brings the counter to the compare value. The compare output is high while the counter is below the compare value.
- R9: Status offset 1 holds the overflow flag in bit 0 and the compare-match flag in bit 1. Writing 1 to a bit clears it, and writing 0 leaves it. Both flags also drive output pins.
- R10: The register offsets are 0 control, 1 status, 2 reload, 3 compare and 4 counter window. Unmapped offsets read 0, and read data is 0 while the bus is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| ext_in | input | 1 | External timer pin (asynchronous) |
| cmp_out | output | 1 | High while counter < compare |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
The assertions check these rules on every cycle:
- The counter holds still unless a tick, a restart or a window write occurs.
- A window write lands on the next edge.
- A tick at 0xFF produces the reload value and raises the overflow flag.
- The disabled source never ticks.
- Flags persist until a clear.
- The reserved bit and the idle bus read 0.

Other rules depend on a whole scenario and only the bench shows them:
- Tick rates for each prescaler code and the divide-by-three source.
- Counting on pin edges.
- Restart on one polarity and not the other.
- Write-precedence over an overflow.
- Compare matching.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned AW    = 3;
  localparam int unsigned PSC_W = 3;

  typedef enum logic [1:0] {
    SRC_FCLK  = 2'b00,
    SRC_FDIV3 = 2'b01,
    SRC_PIN   = 2'b10,
    SRC_OFF   = 2'b11
  } src_e;

  typedef struct packed {
    logic [PSC_W-1:0] psc;
    logic             rsvd;
    logic             pol;
    logic             edge_en;
    src_e             src;
  } ctrl_t;

  localparam logic [AW-1:0] OFS_CTRL   = 3'd0;
  localparam logic [AW-1:0] OFS_STAT   = 3'd1;
  localparam logic [AW-1:0] OFS_RELOAD = 3'd2;
  localparam logic [AW-1:0] OFS_CMP    = 3'd3;
  localparam logic [AW-1:0] OFS_LOAD   = 3'd4;
endpackage

// File: rtl/rtimer_pin_sync.sv
module rtimer_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  // shift chain: stage 0 samples the raw pin
  always_ff @(posedge clk) begin
    if (!rst_n) sh_q[0] <= 1'b0;
    else        sh_q[0] <= pin;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) sh_q[g] <= 1'b0;
      else        sh_q[g] <= sh_q[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sh_q[STAGES-1];
  end

  assign rise = sh_q[STAGES-1] & ~prev_q;
  assign fall = ~sh_q[STAGES-1] & prev_q;
endmodule

// File: rtl/rtimer_tick_gen.sv
module rtimer_tick_gen
  import rtimer_pkg::*;
#(
  parameter int unsigned SEL_W = PSC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  src_e             src,
  input  logic [SEL_W-1:0] psc_sel,
  input  logic             pin_rise,
  input  logic             restart,
  output logic             tick
);
  localparam int unsigned PRE_W = (1 << SEL_W) - 1;

  logic [1:0]       d3_q;
  logic             base;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  // free-running modulo-3 phase
  always_ff @(posedge clk) begin
    if (!rst_n)             d3_q <= 2'd0;
    else if (d3_q == 2'd2)  d3_q <= 2'd0;
    else                    d3_q <= d3_q + 2'd1;
  end

  always_comb begin
    unique case (src)
      SRC_FCLK:  base = 1'b1;
      SRC_FDIV3: base = (d3_q == 2'd2);
      SRC_PIN:   base = pin_rise;
      default:   base = 1'b0;
    endcase
  end

  // prescaler: tap select only changes the mask, never the count
  always_ff @(posedge clk) begin
    if (!rst_n || restart) pre_q <= '0;
    else if (base)         pre_q <= pre_q + 1'b1;
  end

  assign mask = ~({PRE_W{1'b1}} << psc_sel);
  assign tick = base & ((pre_q & mask) == mask) & ~restart;
endmodule

// File: rtl/rtimer_counter.sv
module rtimer_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         tick,
  input  logic         restart,
  input  logic         load_we,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload,
  input  logic [W-1:0] cmp,
  output logic [W-1:0] cnt,
  output logic         ovf_evt,
  output logic         cmp_evt,
  output logic         cmp_out
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] nxt;
  logic         at_top;

  assign at_top = (cnt_q == {W{1'b1}});
  assign nxt    = at_top ? reload : cnt_q + 1'b1;

  // counter is deliberately left without reset
  always_ff @(posedge clk) begin
    if (load_we)      cnt_q <= load_val;
    else if (restart) cnt_q <= reload;
    else if (tick)    cnt_q <= nxt;
  end

  assign ovf_evt = tick & ~load_we & at_top;
  assign cmp_evt = tick & ~load_we & (nxt == cmp);
  assign cmp_out = (cnt_q < cmp);
  assign cnt     = cnt_q;
endmodule

// File: rtl/rtimer_regs.sv
module rtimer_regs
  import rtimer_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] cnt,
  input  logic          ovf_evt,
  input  logic          cmp_evt,
  output ctrl_t         ctrl,
  output logic [DW-1:0] reload,
  output logic [DW-1:0] cmp,
  output logic          load_we,
  output logic          ovf_flag,
  output logic          cmp_flag
);
  logic  wr;
  ctrl_t ctrl_q;
  logic [DW-1:0] reload_q, cmp_q;
  logic  ovf_q, cmpf_q;
  logic  clr_ovf, clr_cmp;

  assign wr      = sel & we;
  assign load_we = wr & (addr == OFS_LOAD);
  assign clr_ovf = wr & (addr == OFS_STAT) & wdata[0];
  assign clr_cmp = wr & (addr == OFS_STAT) & wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      cmp_q    <= '0;
    end else if (wr) begin
      if (addr == OFS_CTRL)   ctrl_q   <= ctrl_t'({wdata[7:5], 1'b0, wdata[3:0]});
      if (addr == OFS_RELOAD) reload_q <= wdata;
      if (addr == OFS_CMP)    cmp_q    <= wdata;
    end
  end

  // sticky flags, an event in the same cycle beats a clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      cmpf_q <= 1'b0;
    end else begin
      ovf_q  <= ovf_evt | (ovf_q & ~clr_ovf);
      cmpf_q <= cmp_evt | (cmpf_q & ~clr_cmp);
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      unique case (addr)
        OFS_CTRL:   rdata = ctrl_q;
        OFS_STAT:   rdata = {{(DW-2){1'b0}}, cmpf_q, ovf_q};
        OFS_RELOAD: rdata = reload_q;
        OFS_CMP:    rdata = cmp_q;
        OFS_LOAD:   rdata = cnt;
        default:    rdata = '0;
      endcase
    end
  end

  assign ctrl     = ctrl_q;
  assign reload   = reload_q;
  assign cmp      = cmp_q;
  assign ovf_flag = ovf_q;
  assign cmp_flag = cmpf_q;
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rtimer_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ext_in,
  output logic          cmp_out,
  output logic          ovf_flag,
  output logic          cmp_flag
);
  ctrl_t         ctrl_q;
  logic [DW-1:0] reload_q, cmp_q, cnt_q;
  logic          load_we, tick, restart;
  logic          pin_rise, pin_fall;
  logic          ovf_evt, cmp_evt;

  rtimer_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_in), .rise(pin_rise), .fall(pin_fall)
  );

  assign restart = ctrl_q.edge_en & (ctrl_q.pol ? pin_fall : pin_rise);

  rtimer_tick_gen #(.SEL_W(PSC_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .src(ctrl_q.src), .psc_sel(ctrl_q.psc),
    .pin_rise(pin_rise), .restart(restart), .tick(tick)
  );

  rtimer_counter #(.W(DW)) u_cnt (
    .clk(clk), .tick(tick), .restart(restart), .load_we(load_we),
    .load_val(bus_wdata), .reload(reload_q), .cmp(cmp_q), .cnt(cnt_q),
    .ovf_evt(ovf_evt), .cmp_evt(cmp_evt), .cmp_out(cmp_out)
  );

  rtimer_regs u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .cnt(cnt_q), .ovf_evt(ovf_evt),
    .cmp_evt(cmp_evt), .ctrl(ctrl_q), .reload(reload_q), .cmp(cmp_q),
    .load_we(load_we), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );
endmodule

// File: rtl/rtimer_chk.sv
module rtimer_chk
  import rtimer_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input ctrl_t         ctrl,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] reload,
  input logic          tick,
  input logic          restart,
  input logic          ldw,
  input logic          ovf_flag
);
  logic stat_clr0;
  assign stat_clr0 = bus_sel && bus_we && bus_addr == OFS_STAT && bus_wdata[0];

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == OFS_CTRL) |-> !bus_rdata[4]); // R2
  AST_SRC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.src == SRC_OFF) |-> !tick); // R4
  AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == 8'hFF && !ldw) |=> (cnt == $past(reload) && ovf_flag)); // R5
  AST_LOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == OFS_LOAD) |=> (cnt == $past(bus_wdata))); // R6
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart && !ldw) |=> $stable(cnt)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !stat_clr0) |=> ovf_flag); // R9
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (bus_rdata == '0)); // R10
endmodule

bind reload_timer rtimer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .ctrl(ctrl_q), .cnt(cnt_q), .reload(reload_q), .tick(tick),
  .restart(restart), .ldw(load_we), .ovf_flag(ovf_flag)
);

// File: tb/test_reload_timer.sv
`timescale 1ns/1ps
module test_reload_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ext_in = 1'b0;
  logic       cmp_out, ovf_flag, cmp_flag;
  logic       chk_rd = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  reload_timer i_reload_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_in(ext_in), .cmp_out(cmp_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  // monitor: pops one expected item per checked read
  always @(negedge clk) begin
    if (chk_rd) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL scoreboard empty: act=%02h exp=none", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_tests++;
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: act=%02h exp=%02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_sel = 1; bus_we = 0; bus_addr = a; chk_rd = 1;
    @(posedge clk); #1;
    bus_sel = 0; chk_rd = 0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); v = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_pin(input string t, input logic act, input logic e);
    @(negedge clk);
    n_tests++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: act=%0b exp=%0b", t, act, e);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] a;
    idle(3);
    rst_n = 1;
    // R7 reset values
    rd(3'd0, 8'h00, "R7 ctrl");
    rd(3'd1, 8'h00, "R7 status");
    rd(3'd2, 8'h00, "R7 reload");
    rd(3'd3, 8'h00, "R7 compare");
    // R10 map
    rd(3'd5, 8'h00, "R10 unmapped 5");
    wr(3'd2, 8'hA7);
    rd(3'd2, 8'hA7, "R10 reload readback");
    // R2 reserved bit, R4 source off
    wr(3'd0, 8'h13);
    rd(3'd0, 8'h03, "R2 reserved bit");
    wr(3'd4, 8'h55);
    idle(10);
    rd(3'd4, 8'h55, "R4 source off holds");
    // R6 / R4 every cycle
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h10);
    rd(3'd4, 8'h10, "R6 window write");
    wr(3'd4, 8'h10);
    idle(5);
    rd(3'd4, 8'h15, "R4 every-cycle count");
    // R1 prescaler /8 and /128
    wr(3'd0, 8'h60);
    wr(3'd4, 8'h00);
    peek(3'd4, a);
    idle(31);
    rd(3'd4, a + 8'd4, "R1 divide by 8");
    wr(3'd0, 8'hE0);
    wr(3'd4, 8'h00);
    peek(3'd4, a);
    idle(255);
    rd(3'd4, a + 8'd2, "R1 divide by 128");
    // R4 divide by 3
    wr(3'd0, 8'h01);
    wr(3'd4, 8'h00);
    peek(3'd4, a);
    idle(14);
    rd(3'd4, a + 8'd5, "R4 divide by 3");
    // R4 pin source
    wr(3'd0, 8'h02);
    wr(3'd4, 8'h20);
    for (int i = 0; i < 3; i++) begin
      ext_in = 1; idle(3);
      ext_in = 0; idle(3);
    end
    idle(4);
    rd(3'd4, 8'h23, "R4 pin rising edges");
    // R5 overflow and reload
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h80);
    wr(3'd4, 8'hFD);
    wr(3'd1, 8'h03);
    idle(2);
    rd(3'd4, 8'h80, "R5 reload after FF");
    rd(3'd1, 8'h01, "R5 overflow flag");
    chk_pin("R9 ovf_flag pin", ovf_flag, 1'b1);
    // R9 write-one-to-clear
    wr(3'd1, 8'h02);
    rd(3'd1, 8'h01, "R9 zero bit keeps flag");
    wr(3'd1, 8'h01);
    rd(3'd1, 8'h00, "R9 one clears flag");
    // R8 compare
    wr(3'd3, 8'h90);
    wr(3'd4, 8'h8E);
    wr(3'd1, 8'h03);
    idle(1);
    rd(3'd1, 8'h02, "R8 compare flag");
    chk_pin("R8 cmp_flag pin", cmp_flag, 1'b1);
    chk_pin("R8 cmp_out above", cmp_out, 1'b0);
    wr(3'd4, 8'h10);
    chk_pin("R8 cmp_out below", cmp_out, 1'b1);
    // R6 write beats overflow
    wr(3'd1, 8'h03);
    wr(3'd4, 8'hFF);
    wr(3'd4, 8'h30);
    rd(3'd4, 8'h30, "R6 write beats reload");
    rd(3'd1, 8'h00, "R6 no overflow flagged");
    // R3 restart
    wr(3'd0, 8'h07);
    wr(3'd2, 8'h40);
    wr(3'd4, 8'h05);
    ext_in = 1; idle(5);
    rd(3'd4, 8'h40, "R3 rising restart");
    wr(3'd0, 8'h03);
    wr(3'd4, 8'h05);
    ext_in = 0; idle(4);
    ext_in = 1; idle(5);
    rd(3'd4, 8'h05, "R3 restart disabled");
    wr(3'd0, 8'h0F);
    wr(3'd4, 8'h05);
    ext_in = 0; idle(5);
    rd(3'd4, 8'h40, "R3 falling restart");
    wr(3'd4, 8'h05);
    ext_in = 1; idle(5);
    rd(3'd4, 8'h05, "R3 wrong polarity ignored");
    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule